// File: doc/BRIEF.md
# Double-Integer ALU

A 32-bit signed integer execution unit for a 16-bit machine. The unit takes two 32-bit operands, a 4-bit function code and the current extend (E) and overflow (O) flags. It returns a 32-bit result as a high word and a low word, the updated E and O flags, and a skip count of 0, 1 or 2 words. The instruction sequencer uses the skip count to step past words after branch-like functions.

A one-cycle `start` pulse captures the operands, the function code and the incoming flags. Multiply, divide and reversed divide take `LONG_CYCLES` clocks. Every other function takes one clock. Completion is a single-cycle `done` pulse, and the result, flag and skip outputs hold their values until the next completion. The E flag is sticky: carry and borrow are ORed into the incoming E and never clear it. Multiply and divide overflows saturate to the largest positive value.

Function codes 13 to 15 are not defined. They raise `badFunc` and leave the result words unchanged. A self-test function reports a revision and a pass code on side outputs.

Top module: `dint_unit`

## Requirements
- R1: The 32-bit result is presented with bits 31:16 on `resHi` and bits 15:0 on `resLo`. Add (code 1) returns the wrapped sum, and O is set exactly when the signed sum does not fit in 32 bits.
- R2: For add (code 1), E out is E in OR the unsigned carry out of bit 31. For subtract (code 7, X-Y) and reversed subtract (code 12, Y-X), the result is the wrapped difference, E out is E in OR (minuend < subtrahend, unsigned), and O flags signed overflow.
- R3: Multiply (code 2) forms the signed 64-bit product. If the product lies outside the signed 32-bit range, O=1 and the result is 0x7FFFFFFF. Otherwise O=0, the result is the low 32 bits, and E is unchanged.
- R4: Divide (code 5, X/Y) and reversed divide (code 6, Y/X) return the signed quotient truncated toward zero with O=0. If the divisor is zero, or the dividend is 0x80000000 and the divisor is -1, then O=1 and the result is 0x7FFFFFFF. E is unchanged.
- R5: Negate (code 3) returns -X. O=1 only for X=0x80000000. E is forced to 1 when X is zero and otherwise keeps its incoming value.
- R6: Increment (code 8) returns X+1, with O=1 only when the result is 0x80000000 and E forced to 1 when the result is zero. Decrement (code 9) returns X-1, with O=1 only when the result is 0x7FFFFFFF and E forced to 1 when the result is 0xFFFFFFFF.
- R7: Compare (code 4) returns X unchanged. The skip count is 0 when X equals Y, 1 when X < Y (signed) and 2 when X > Y. E and O pass through unchanged.
- R8: Increment-skip (code 10) returns X+1 and decrement-skip (code 11) returns X-1. Each gives skip 1 when its result is zero and 0 otherwise, and leaves E and O unchanged.
- R9: Self-test (code 0) leaves `resHi` unchanged, sets `resLo` to octal 377, sets skip to 1, sets `revision` to 2 and sets `passCode` to octal 102077. E and O are unchanged.
- R10: Codes 13, 14 and 15 raise `badFunc` for that completion. They leave `resHi`, `resLo`, E and O unchanged and give skip 0. Every defined code completes with `badFunc` low.
- R11: `done` is a one-cycle pulse that appears one clock after the capturing edge for single-cycle codes, and `LONG_CYCLES` clocks after it for codes 2, 5 and 6. A `start` that arrives while an operation is in flight is ignored.
- R12: After reset, `done`, `resHi`, `resLo`, `eOut`, `oOut`, `skip`, `badFunc`, `revision` and `passCode` are all zero. Skip is 0 for every code other than 0, 4, 10 and 11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an operation (ignored while busy) |
| func | input | 4 | Function code |
| opX | input | 32 | First operand |
| opY | input | 32 | Second operand |
| eIn | input | 1 | Incoming extend flag |
| oIn | input | 1 | Incoming overflow flag |
| done | output | 1 | One-cycle completion pulse |
| resHi | output | 16 | Result bits 31:16 |
| resLo | output | 16 | Result bits 15:0 |
| eOut | output | 1 | Updated extend flag |
| oOut | output | 1 | Updated overflow flag |
| skip | output | 2 | Words to skip (0, 1 or 2) |
| badFunc | output | 1 | Undefined function code completed |
| revision | output | 16 | Revision reported by self-test |
| passCode | output | 16 | Pass code reported by self-test |

## Verification
The arithmetic functions are driven at the sign and carry boundaries where E and O diverge. An unsigned wrap with no signed overflow (0xFFFFFFFF+1) sets E but not O. A signed wrap with no carry (0x7FFFFFFF+1) sets O but not E. An incoming E of 1 with no carry shows that the flag is ORed and never cleared.

Multiply is tried with a product exactly at -2^31, which must not saturate, against one just outside the range, which must saturate. Divide is tried with a zero divisor and with 0x80000000 ÷ -1, and a negative odd dividend checks truncation toward zero. The reversed forms reuse the same operands, so any result that matches the unswapped form exposes a missing swap.

Compare runs with less, equal and greater operands whose unsigned and signed orders disagree. Undefined codes, self-test, and a start issued in the middle of a long operation check what stays unchanged.

// File: rtl/dint_pkg.sv
package dint_pkg;

  localparam logic [3:0] FN_TEST = 4'd0;
  localparam logic [3:0] FN_ADD  = 4'd1;
  localparam logic [3:0] FN_MUL  = 4'd2;
  localparam logic [3:0] FN_NEG  = 4'd3;
  localparam logic [3:0] FN_CMP  = 4'd4;
  localparam logic [3:0] FN_DIV  = 4'd5;
  localparam logic [3:0] FN_DIVR = 4'd6;
  localparam logic [3:0] FN_SUB  = 4'd7;
  localparam logic [3:0] FN_INC  = 4'd8;
  localparam logic [3:0] FN_DEC  = 4'd9;
  localparam logic [3:0] FN_INCZ = 4'd10;
  localparam logic [3:0] FN_DECZ = 4'd11;
  localparam logic [3:0] FN_SUBR = 4'd12;

  localparam int REV_CODE  = 2;
  localparam int PASS_CODE = 'o102077;
  localparam int TEST_LOW  = 'o377;

  // strobes from control to datapath
  typedef struct packed {
    logic capture;
    logic commit;
  } strobes_t;

  function automatic logic isLongFn(input logic [3:0] f);
    return (f == FN_MUL) || (f == FN_DIV) || (f == FN_DIVR);
  endfunction

endpackage

// File: rtl/dint_ctrl.sv
module dint_ctrl
  import dint_pkg::*;
#(
  parameter int LONG_CYCLES = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic [3:0] func,
  output strobes_t   strb,
  output logic       done
);

  localparam int CW = $clog2(LONG_CYCLES + 1);

  logic          busy;
  logic [CW-1:0] cnt;

  always_comb begin
    strb.capture = start && !busy;
    strb.commit  = busy && (cnt == '0);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy <= 1'b0;
      cnt  <= '0;
      done <= 1'b0;
    end else begin
      done <= strb.commit;
      if (strb.capture) begin
        busy <= 1'b1;
        cnt  <= isLongFn(func) ? CW'(LONG_CYCLES - 1) : '0;
      end else if (strb.commit) begin
        busy <= 1'b0;
      end else if (busy) begin
        cnt <= cnt - 1'b1;
      end
    end
  end

endmodule

// File: rtl/dint_path.sv
module dint_path
  import dint_pkg::*;
#(
  parameter int WORD_W = 16
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  strobes_t              strb,
  input  logic [3:0]            funcIn,
  input  logic [2*WORD_W-1:0]   opXIn,
  input  logic [2*WORD_W-1:0]   opYIn,
  input  logic                  eIn,
  input  logic                  oIn,
  output logic [WORD_W-1:0]     resHi,
  output logic [WORD_W-1:0]     resLo,
  output logic                  eOut,
  output logic                  oOut,
  output logic [1:0]            skip,
  output logic                  badFunc,
  output logic [WORD_W-1:0]     revision,
  output logic [WORD_W-1:0]     passCode
);

  localparam int DW = 2 * WORD_W;
  localparam logic [DW-1:0] MAX_POS = {1'b0, {(DW-1){1'b1}}};
  localparam logic [DW-1:0] MIN_NEG = {1'b1, {(DW-1){1'b0}}};
  localparam logic [DW-1:0] ONE     = DW'(1);

  logic [3:0]    fnQ;
  logic [DW-1:0] xQ, yQ;
  logic          eQ, oQ;

  logic                 swapOps;
  logic [DW-1:0]        opA, opB, cur, tNew, diff, quo, bSafe, incV, decV;
  logic [DW:0]          sum;
  logic signed [2*DW-1:0] prod;
  logic addOvf, subOvf, mulOvf, divOvf;
  logic eNew, oNew, badNew;
  logic [1:0] skipNew;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      fnQ <= '0; xQ <= '0; yQ <= '0; eQ <= 1'b0; oQ <= 1'b0;
    end else if (strb.capture) begin
      fnQ <= funcIn; xQ <= opXIn; yQ <= opYIn; eQ <= eIn; oQ <= oIn;
    end
  end

  always_comb begin
    swapOps = (fnQ == FN_DIVR) || (fnQ == FN_SUBR);
    opA     = swapOps ? yQ : xQ;
    opB     = swapOps ? xQ : yQ;
    cur     = {resHi, resLo};
    sum     = {1'b0, opA} + {1'b0, opB};
    addOvf  = (opA[DW-1] == opB[DW-1]) && (sum[DW-1] != opA[DW-1]);
    diff    = opA - opB;
    subOvf  = (opA[DW-1] != opB[DW-1]) && (diff[DW-1] != opA[DW-1]);
    prod    = $signed(opA) * $signed(opB);
    mulOvf  = !((&prod[2*DW-1:DW-1]) || !(|prod[2*DW-1:DW-1]));
    divOvf  = (opB == '0) || ((opA == MIN_NEG) && (opB == '1));
    bSafe   = divOvf ? ONE : opB;
    quo     = DW'($signed(opA) / $signed(bSafe));
    incV    = opA + ONE;
    decV    = opA - ONE;

    tNew    = cur;
    eNew    = eQ;
    oNew    = oQ;
    skipNew = 2'd0;
    badNew  = 1'b0;
    case (fnQ)
      FN_TEST: begin
        tNew    = {resHi, WORD_W'(TEST_LOW)};
        skipNew = 2'd1;
      end
      FN_ADD: begin
        tNew = sum[DW-1:0];
        eNew = eQ | sum[DW];
        oNew = addOvf;
      end
      FN_SUB, FN_SUBR: begin
        tNew = diff;
        eNew = eQ | (opA < opB);
        oNew = subOvf;
      end
      FN_MUL: begin
        tNew = mulOvf ? MAX_POS : prod[DW-1:0];
        oNew = mulOvf;
      end
      FN_DIV, FN_DIVR: begin
        tNew = divOvf ? MAX_POS : quo;
        oNew = divOvf;
      end
      FN_NEG: begin
        tNew = '0 - opA;
        oNew = (opA == MIN_NEG);
        eNew = eQ | (opA == '0);
      end
      FN_INC: begin
        tNew = incV;
        oNew = (incV == MIN_NEG);
        eNew = eQ | (incV == '0);
      end
      FN_DEC: begin
        tNew = decV;
        oNew = (decV == MAX_POS);
        eNew = eQ | (decV == '1);
      end
      FN_INCZ: begin
        tNew    = incV;
        skipNew = (incV == '0) ? 2'd1 : 2'd0;
      end
      FN_DECZ: begin
        tNew    = decV;
        skipNew = (decV == '0) ? 2'd1 : 2'd0;
      end
      FN_CMP: begin
        tNew = opA;
        if ($signed(opA) < $signed(opB))      skipNew = 2'd1;
        else if ($signed(opA) > $signed(opB)) skipNew = 2'd2;
      end
      default: badNew = 1'b1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      resHi <= '0; resLo <= '0; eOut <= 1'b0; oOut <= 1'b0;
      skip <= 2'd0; badFunc <= 1'b0; revision <= '0; passCode <= '0;
    end else if (strb.commit) begin
      resHi   <= tNew[DW-1:WORD_W];
      resLo   <= tNew[WORD_W-1:0];
      eOut    <= eNew;
      oOut    <= oNew;
      skip    <= skipNew;
      badFunc <= badNew;
      if (fnQ == FN_TEST) begin
        revision <= WORD_W'(REV_CODE);
        passCode <= WORD_W'(PASS_CODE);
      end
    end
  end

endmodule

// File: rtl/dint_unit.sv
module dint_unit
  import dint_pkg::*;
#(
  parameter int WORD_W      = 16,
  parameter int LONG_CYCLES = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                start,
  input  logic [3:0]          func,
  input  logic [2*WORD_W-1:0] opX,
  input  logic [2*WORD_W-1:0] opY,
  input  logic                eIn,
  input  logic                oIn,
  output logic                done,
  output logic [WORD_W-1:0]   resHi,
  output logic [WORD_W-1:0]   resLo,
  output logic                eOut,
  output logic                oOut,
  output logic [1:0]          skip,
  output logic                badFunc,
  output logic [WORD_W-1:0]   revision,
  output logic [WORD_W-1:0]   passCode
);

  strobes_t strb;

  dint_ctrl #(.LONG_CYCLES(LONG_CYCLES)) uCtrl (
    .clk(clk), .rstN(rstN), .start(start), .func(func),
    .strb(strb), .done(done)
  );

  dint_path #(.WORD_W(WORD_W)) uPath (
    .clk(clk), .rstN(rstN), .strb(strb), .funcIn(func),
    .opXIn(opX), .opYIn(opY), .eIn(eIn), .oIn(oIn),
    .resHi(resHi), .resLo(resLo), .eOut(eOut), .oOut(oOut),
    .skip(skip), .badFunc(badFunc), .revision(revision), .passCode(passCode)
  );

endmodule

// File: rtl/dint_checker.sv
module dint_checker
  import dint_pkg::*;
#(
  parameter int WORD_W      = 16,
  parameter int LONG_CYCLES = 4
) (
  input logic                clk,
  input logic                rstN,
  input logic                start,
  input logic [3:0]          func,
  input logic [2*WORD_W-1:0] opX,
  input logic [2*WORD_W-1:0] opY,
  input logic                eIn,
  input logic                oIn,
  input logic                done,
  input logic [WORD_W-1:0]   resHi,
  input logic [WORD_W-1:0]   resLo,
  input logic                eOut,
  input logic                oOut,
  input logic [1:0]          skip,
  input logic                badFunc,
  input logic [WORD_W-1:0]   revision,
  input logic [WORD_W-1:0]   passCode
);

  localparam int DW = 2 * WORD_W;
  localparam logic [DW-1:0] MAX_POS = {1'b0, {(DW-1){1'b1}}};
  localparam logic [DW-1:0] MIN_NEG = {1'b1, {(DW-1){1'b0}}};

  logic          busyQ, eQ, oQ;
  logic [3:0]    fnQ;
  logic [DW-1:0] xQ, yQ;
  logic          accept;

  assign accept = start && (!busyQ || done);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busyQ <= 1'b0; fnQ <= '0; xQ <= '0; yQ <= '0; eQ <= 1'b0; oQ <= 1'b0;
    end else if (accept) begin
      busyQ <= 1'b1; fnQ <= func; xQ <= opX; yQ <= opY; eQ <= eIn; oQ <= oIn;
    end else if (done) begin
      busyQ <= 1'b0;
    end
  end

  assert_mul_sat_R3: assert property (@(posedge clk) disable iff (!rstN)
    done && oOut && fnQ == FN_MUL |-> {resHi, resLo} == MAX_POS);

  assert_div_sat_R4: assert property (@(posedge clk) disable iff (!rstN)
    done && fnQ == FN_DIV && yQ == '0 |-> oOut && {resHi, resLo} == MAX_POS);

  assert_inc_ovf_R6: assert property (@(posedge clk) disable iff (!rstN)
    done && fnQ == FN_INC |-> oOut == ({resHi, resLo} == MIN_NEG));

  assert_cmp_keep_R7: assert property (@(posedge clk) disable iff (!rstN)
    done && fnQ == FN_CMP |-> eOut == eQ && oOut == oQ && {resHi, resLo} == xQ
                              && ((skip == 2'd0) == (xQ == yQ)));

  assert_skip_range_R7: assert property (@(posedge clk) disable iff (!rstN)
    done |-> skip != 2'd3);

  assert_selftest_R9: assert property (@(posedge clk) disable iff (!rstN)
    done && fnQ == FN_TEST |-> revision == WORD_W'(REV_CODE)
                               && passCode == WORD_W'(PASS_CODE) && skip == 2'd1);

  assert_bad_flag_R10: assert property (@(posedge clk) disable iff (!rstN)
    done |-> badFunc == (fnQ >= 4'd13));

  assert_bad_hold_R10: assert property (@(posedge clk) disable iff (!rstN)
    done && badFunc |-> $stable(resHi) && $stable(resLo));

  assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

endmodule

bind dint_unit dint_checker #(.WORD_W(WORD_W), .LONG_CYCLES(LONG_CYCLES)) uChk (.*);

// File: tb/sim_dint_unit.sv
`timescale 1ns/1ps
module sim_dint_unit;

  localparam int LAT = 4;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [3:0]  func = '0;
  logic [31:0] opX = '0, opY = '0;
  logic        eIn = 1'b0, oIn = 1'b0;
  logic        done, eOut, oOut, badFunc;
  logic [15:0] resHi, resLo, revision, passCode;
  logic [1:0]  skip;

  int total = 0;
  int bad = 0;

  logic [15:0] mHi = '0, mLo = '0, mRev = '0, mPass = '0;

  always #4 clk = ~clk;

  dint_unit #(.WORD_W(16), .LONG_CYCLES(LAT)) u0 (
    .clk(clk), .rstN(rstN), .start(start), .func(func), .opX(opX), .opY(opY),
    .eIn(eIn), .oIn(oIn), .done(done), .resHi(resHi), .resLo(resLo),
    .eOut(eOut), .oOut(oOut), .skip(skip), .badFunc(badFunc),
    .revision(revision), .passCode(passCode)
  );

  task automatic check(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // behavioural reference and handshake check for one operation
  task automatic runOp(input string req, input logic [3:0] f,
                       input logic [31:0] x, input logic [31:0] y,
                       input logic e, input logic o, input bit intrude = 1'b0);
    logic [31:0] a, b, r;
    logic        xe, xo, xb;
    logic [1:0]  xs;
    longint      wide;
    int          lat;
    a = x; b = y;
    if (f == 4'd6 || f == 4'd12) begin a = y; b = x; end
    r = {mHi, mLo}; xe = e; xo = o; xs = 2'd0; xb = 1'b0;
    case (f)
      4'd0: begin r = {mHi, 16'o377}; xs = 2'd1; mRev = 16'd2; mPass = 16'o102077; end
      4'd1: begin
        wide = longint'(a) + longint'(b);
        r = wide[31:0]; xe = e | wide[32];
        wide = longint'(int'(a)) + longint'(int'(b));
        xo = (wide > 64'sd2147483647) || (wide < -64'sd2147483648);
      end
      4'd7, 4'd12: begin
        r = a - b; xe = e | (a < b);
        wide = longint'(int'(a)) - longint'(int'(b));
        xo = (wide > 64'sd2147483647) || (wide < -64'sd2147483648);
      end
      4'd2: begin
        wide = longint'(int'(a)) * longint'(int'(b));
        xo = (wide > 64'sd2147483647) || (wide < -64'sd2147483648);
        r = xo ? 32'h7FFFFFFF : wide[31:0];
      end
      4'd5, 4'd6: begin
        xo = (b == 0) || (a == 32'h80000000 && b == 32'hFFFFFFFF);
        r = xo ? 32'h7FFFFFFF : 32'(int'(a) / int'(b));
      end
      4'd3: begin r = 32'd0 - a; xo = (a == 32'h80000000); if (a == 0) xe = 1'b1; end
      4'd8: begin r = a + 1; xo = (r == 32'h80000000); if (r == 0) xe = 1'b1; end
      4'd9: begin r = a - 1; xo = (r == 32'h7FFFFFFF); if (r == 32'hFFFFFFFF) xe = 1'b1; end
      4'd10: begin r = a + 1; xs = (r == 0) ? 2'd1 : 2'd0; end
      4'd11: begin r = a - 1; xs = (r == 0) ? 2'd1 : 2'd0; end
      4'd4: begin
        r = a;
        if (int'(a) < int'(b)) xs = 2'd1; else if (int'(a) > int'(b)) xs = 2'd2;
      end
      default: xb = 1'b1;
    endcase
    lat = (f == 4'd2 || f == 4'd5 || f == 4'd6) ? LAT : 1;

    @(negedge clk);
    start = 1'b1; func = f; opX = x; opY = y; eIn = e; oIn = o;
    @(negedge clk);
    start = 1'b0;
    for (int cyc = 1; cyc <= lat; cyc++) begin
      if (cyc < lat) check(req, "done early", done, 0);
      if (intrude && cyc == 1) begin
        start = 1'b1; func = 4'd1; opX = 32'h12345678; opY = 32'h1; eIn = 1'b1;
      end
      if (intrude && cyc == 2) start = 1'b0;
      @(negedge clk);
    end
    check(req, "done", done, 1);
    check(req, "resHi", resHi, r[31:16]);
    check(req, "resLo", resLo, r[15:0]);
    check(req, "eOut", eOut, xe);
    check(req, "oOut", oOut, xo);
    check(req, "skip", skip, xs);
    check(req, "badFunc", badFunc, xb);
    check(req, "revision", revision, mRev);
    check(req, "passCode", passCode, mPass);
    mHi = r[31:16]; mLo = r[15:0];
    @(negedge clk);
    check(req, "done pulse", done, 0);
    if (intrude) begin
      @(negedge clk);
      check("R11", "ignored start", done, 0);
      check("R11", "held result", {resHi, resLo}, r);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R12 reset state
    check("R12", "reset done", done, 0);
    check("R12", "reset result", {resHi, resLo}, 0);
    check("R12", "reset flags", {eOut, oOut, badFunc, skip}, 0);
    check("R12", "reset side", {revision, passCode}, 0);

    runOp("R1", 4'd1, 32'h0001FFFF, 32'h00000001, 1'b0, 1'b0);
    runOp("R1", 4'd1, 32'h7FFFFFFF, 32'h00000001, 1'b0, 1'b0);
    runOp("R2", 4'd1, 32'hFFFFFFFF, 32'h00000001, 1'b0, 1'b1);
    runOp("R2", 4'd1, 32'h00000005, 32'h00000006, 1'b1, 1'b0);
    runOp("R2", 4'd7, 32'h00000001, 32'h00000002, 1'b0, 1'b0);
    runOp("R2", 4'd7, 32'h80000000, 32'h00000001, 1'b0, 1'b0);
    runOp("R2", 4'd12, 32'h00000001, 32'h00000002, 1'b0, 1'b1);
    runOp("R3", 4'd2, 32'd1000, 32'hFFFFFFFD, 1'b0, 1'b1);
    runOp("R3", 4'd2, 32'h00010000, 32'h00010000, 1'b1, 1'b0);
    runOp("R3", 4'hF & 4'd2, 32'hFFFF0000, 32'h00008000, 1'b0, 1'b1);
    runOp("R4", 4'd5, 32'hFFFFFFF9, 32'd2, 1'b0, 1'b1);
    runOp("R4", 4'd5, 32'd9, 32'd0, 1'b1, 1'b0);
    runOp("R4", 4'd5, 32'h80000000, 32'hFFFFFFFF, 1'b0, 1'b0);
    runOp("R4", 4'd6, 32'd3, 32'd100, 1'b0, 1'b0);
    runOp("R5", 4'd3, 32'd0, 32'd0, 1'b0, 1'b1);
    runOp("R5", 4'd3, 32'h80000000, 32'd0, 1'b0, 1'b0);
    runOp("R5", 4'd3, 32'd7, 32'd0, 1'b1, 1'b1);
    runOp("R6", 4'd8, 32'h7FFFFFFF, 32'd0, 1'b0, 1'b0);
    runOp("R6", 4'd8, 32'hFFFFFFFF, 32'd0, 1'b0, 1'b1);
    runOp("R6", 4'd9, 32'h80000000, 32'd0, 1'b0, 1'b0);
    runOp("R6", 4'd9, 32'd0, 32'd0, 1'b0, 1'b1);
    runOp("R7", 4'd4, 32'hFFFFFFFF, 32'd1, 1'b1, 1'b0);
    runOp("R7", 4'd4, 32'd1, 32'hFFFFFFFF, 1'b0, 1'b1);
    runOp("R7", 4'd4, 32'h00ABCDEF, 32'h00ABCDEF, 1'b1, 1'b1);
    runOp("R8", 4'd10, 32'hFFFFFFFF, 32'd0, 1'b1, 1'b0);
    runOp("R8", 4'd10, 32'd4, 32'd0, 1'b0, 1'b1);
    runOp("R8", 4'd11, 32'd1, 32'd0, 1'b0, 1'b0);
    runOp("R9", 4'd0, 32'd0, 32'd0, 1'b1, 1'b0);
    runOp("R10", 4'd13, 32'h11112222, 32'h3, 1'b0, 1'b1);
    runOp("R10", 4'd14, 32'h11112222, 32'h3, 1'b1, 1'b0);
    runOp("R10", 4'd15, 32'h11112222, 32'h3, 1'b0, 1'b0);
    runOp("R11", 4'd2, 32'd12, 32'd11, 1'b0, 1'b0, 1'b1);
    runOp("R12", 4'd1, 32'd20, 32'd22, 1'b0, 1'b0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule